// File: doc/BRIEF.md
# Bus Monitor with Event Qualification

This block sits beside a 16-bit system bus and watches it without driving it. On each cycle that a programmable sample qualifier accepts, the bus word is compared against two stored patterns, each with its own don't-care mask. The two comparisons produce a start event (A) and a stop or pause event (B). One of eight protocol state machines uses these events to decide whether the word is written into a 1024-entry trace memory and whether the halt output fires.

The halt output is registered and sticky, so it can hold a processor. It stays high until software clears it. For buses wider than 16 bits, several monitors can be chained: a neighbour's halt output feeds this block's cascade input, which gates both comparisons. Configuration, status and trace readback all use one small register port. A write on that port takes effect at the next clock edge, and a read returns data combinationally.

Top module: `bus_event_monitor`

## Requirements
- R1: After reset, `eq_out` is 0, and reads of the control register (address 0) and of the status register (address 5) both return 0.
- R2: An event compare hits when `((bus_data ^ pattern) & ~mask) == 0`, where a mask bit of 1 means don't care. Event A uses pattern address 1 and mask address 2. Event B uses pattern address 3 and mask address 4. When control bit 8 is set, both hits also require `eq_in` to be 1.
- R3: A cycle is sampled only when all of the following hold: control bit 9 (arm) is set, `cfg_we` is 0, the protocol is not finished, and the qualifier passes. The qualifier takes the strobes selected by control bits 6:4 (bit 4 selects `bus_strobe[0]`). It combines them with AND when control bit 7 is 1, and with OR otherwise. Control bit 3 then inverts the result.
- R4: Protocol 0 (control bits 2:0) stores every sampled word and never raises `eq_out`.
- R5: Protocol 1 stores only the sampled words that hit A, and raises `eq_out` on such a word.
- R6: Protocol 2 starts storing at the first A hit, including that word. It keeps storing up to and including the first B hit, then finishes and raises `eq_out`. An A and B hit on the same word stores exactly that one word and finishes.
- R7: Protocol 3 behaves as follows. While paused, an A hit is stored and storing resumes. While storing, a B hit pauses storing without storing that word and raises `eq_out`; B has priority over A in this state. The protocol never finishes.
- R8: Protocol 4 starts storing at the first A hit. It finishes and raises `eq_out` on the store that fills the last address.
- R9: Protocol 5 stores every sampled word until the first B hit. That word is not stored, the protocol finishes, and `eq_out` rises.
- R10: Protocols 6 and 7 store nothing. Protocol 6 raises `eq_out` on any A hit. Protocol 7 raises `eq_out` and finishes on a B hit that arrives on a later sample than the first A hit.
- R11: The write address advances by one on each store and wraps from 1023 to 0. The full flag is set on the first wrap.
- R12: `eq_out` rises at the clock edge that samples the event word. It stays high until a write to address 5 with bit 0 set. A write to address 5 with bit 1 set clears the write address and the full flag and restarts the protocol. Any write to address 0 also restarts the protocol.
- R13: The status word (address 5) has the full flag in bit 15, `eq_out` in bit 14, the finished flag in bit 13 and the write address in bits 9:0. Address 6 holds the trace read index. Address 7 returns the trace word at that index. Addresses 0 to 4 read back their written values, and addresses 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 16 | Observed bus word |
| bus_strobe | input | 3 | System strobes used by the sample qualifier |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| eq_in | input | 1 | Cascade input from a neighbouring monitor |
| eq_out | output | 1 | Registered, sticky halt/event output |

## Verification
The bench targets the following corner cases, and each one shows up as a wrong status word, a wrong trace word or a wrong `eq_out` cycle:
- An A and B hit on the same word in protocols 2, 3 and 7. A design with the wrong priority stores an extra word, fails to pause, or halts one sample too early.
- Configuration cycles carrying matching bus data. A monitor that samples during a write grows its write address.
- Masked bits and a low cascade input. A design that ignores these stores the wrong words.
- A full 1024-word fill in protocol 4. An off-by-one in the wrap stops at the wrong address or leaves the full flag clear.
- Clearing `eq_out` without clearing the address, then the reverse. This exposes clear bits that are crossed.

// File: rtl/bem_pkg.sv
package bem_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mon_state_e;

    localparam logic [2:0] P_ALL       = 3'd0;
    localparam logic [2:0] P_ON_A      = 3'd1;
    localparam logic [2:0] P_START_STOP = 3'd2;
    localparam logic [2:0] P_PAUSE     = 3'd3;
    localparam logic [2:0] P_FILL      = 3'd4;
    localparam logic [2:0] P_UNTIL_B   = 3'd5;
    localparam logic [2:0] P_BRK_A     = 3'd6;
    localparam logic [2:0] P_BRK_AB    = 3'd7;

    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_PAT_A  = 4'd1;
    localparam logic [3:0] RA_MASK_A = 4'd2;
    localparam logic [3:0] RA_PAT_B  = 4'd3;
    localparam logic [3:0] RA_MASK_B = 4'd4;
    localparam logic [3:0] RA_STATUS = 4'd5;
    localparam logic [3:0] RA_IDX    = 4'd6;
    localparam logic [3:0] RA_TRACE  = 4'd7;

endpackage

// File: rtl/bem_match.sv
module bem_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] mask,
    input  logic         gate_en,
    input  logic         gate_in,
    output logic         hit
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (val ^ pat) & ~mask;
        hit  = (diff == '0) && (!gate_en || gate_in);
    end
endmodule

// File: rtl/bem_qual.sv
module bem_qual #(
    parameter int NS = 3
) (
    input  logic [NS-1:0] strobe,
    input  logic [NS+1:0] sel,      // [0] invert, [NS:1] pick, [NS+1] AND mode
    output logic          qual
);
    logic [NS-1:0] pick;
    logic          any_v;
    logic          all_v;

    always_comb begin
        pick  = sel[NS:1];
        any_v = 1'b0;
        all_v = 1'b1;
        for (int i = 0; i < NS; i++) begin
            if (pick[i]) begin
                any_v = any_v | strobe[i];
                all_v = all_v & strobe[i];
            end
        end
        qual = (sel[NS+1] ? all_v : any_v) ^ sel[0];
    end
endmodule

// File: rtl/bem_trace_ram.sv
module bem_trace_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/bus_event_monitor.sv
module bus_event_monitor
    import bem_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    parameter int NS    = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_data,
    input  logic [NS-1:0] bus_strobe,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          eq_in,
    output logic          eq_out
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam int QS_LO = 3;
    localparam int QS_HI = QS_LO + NS + 1;
    localparam int CASC_BIT = QS_HI + 1;
    localparam int ARM_BIT  = QS_HI + 2;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] pat_a;
        logic [DW-1:0] mask_a;
        logic [DW-1:0] pat_b;
        logic [DW-1:0] mask_b;
        logic [AW-1:0] waddr;
        logic [AW-1:0] ridx;
        logic          full;
        logic          eq;
        mon_state_e    st;
    } regs_t;

    regs_t q, d;

    logic          hit_a, hit_b, qual, store, wr_en;
    logic [2:0]    proto;
    logic          arm, casc;
    logic [DW-1:0] trace_word, status_w;

    assign proto = q.ctrl[2:0];
    assign arm   = q.ctrl[ARM_BIT];
    assign casc  = q.ctrl[CASC_BIT];

    bem_match #(.W(DW)) u_match_a (
        .val(bus_data), .pat(q.pat_a), .mask(q.mask_a),
        .gate_en(casc), .gate_in(eq_in), .hit(hit_a)
    );

    bem_match #(.W(DW)) u_match_b (
        .val(bus_data), .pat(q.pat_b), .mask(q.mask_b),
        .gate_en(casc), .gate_in(eq_in), .hit(hit_b)
    );

    bem_qual #(.NS(NS)) u_qual (
        .strobe(bus_strobe), .sel(q.ctrl[QS_HI:QS_LO]), .qual(qual)
    );

    bem_trace_ram #(.W(DW), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(wr_en), .waddr(q.waddr), .wdata(bus_data),
        .raddr(q.ridx), .rdata(trace_word)
    );

    always_comb begin
        d     = q;
        store = 1'b0;
        wr_en = 1'b0;
        if (cfg_we) begin
            case (cfg_addr)
                RA_CTRL: begin
                    d.ctrl = cfg_wdata;
                    d.st   = ST_WAIT;
                end
                RA_PAT_A:  d.pat_a  = cfg_wdata;
                RA_MASK_A: d.mask_a = cfg_wdata;
                RA_PAT_B:  d.pat_b  = cfg_wdata;
                RA_MASK_B: d.mask_b = cfg_wdata;
                RA_STATUS: begin
                    if (cfg_wdata[0]) d.eq = 1'b0;
                    if (cfg_wdata[1]) begin
                        d.waddr = '0;
                        d.full  = 1'b0;
                        d.st    = ST_WAIT;
                    end
                end
                RA_IDX:  d.ridx = cfg_wdata[AW-1:0];
                default: ;
            endcase
        end else if (arm && qual && q.st != ST_DONE) begin
            case (proto)
                P_ALL: store = 1'b1;
                P_ON_A: begin
                    if (hit_a) begin
                        store = 1'b1;
                        d.eq  = 1'b1;
                    end
                end
                P_START_STOP: begin
                    if (q.st == ST_RUN || hit_a) begin
                        store = 1'b1;
                        d.st  = ST_RUN;
                        if (hit_b) begin
                            d.st = ST_DONE;
                            d.eq = 1'b1;
                        end
                    end
                end
                P_PAUSE: begin
                    if (q.st == ST_WAIT) begin
                        if (hit_a) begin
                            store = 1'b1;
                            d.st  = ST_RUN;
                        end
                    end else if (hit_b) begin
                        d.st = ST_WAIT;
                        d.eq = 1'b1;
                    end else begin
                        store = 1'b1;
                    end
                end
                P_FILL: begin
                    if (q.st == ST_RUN || hit_a) begin
                        store = 1'b1;
                        d.st  = ST_RUN;
                    end
                end
                P_UNTIL_B: begin
                    if (hit_b) begin
                        d.st = ST_DONE;
                        d.eq = 1'b1;
                    end else begin
                        store = 1'b1;
                    end
                end
                P_BRK_A: begin
                    if (hit_a) d.eq = 1'b1;
                end
                default: begin
                    if (q.st == ST_WAIT) begin
                        if (hit_a) d.st = ST_RUN;
                    end else if (hit_b) begin
                        d.st = ST_DONE;
                        d.eq = 1'b1;
                    end
                end
            endcase
            if (store) begin
                wr_en = 1'b1;
                if (q.waddr == LAST) begin
                    d.waddr = '0;
                    d.full  = 1'b1;
                    if (proto == P_FILL) begin
                        d.st = ST_DONE;
                        d.eq = 1'b1;
                    end
                end else begin
                    d.waddr = q.waddr + 1'b1;
                end
            end
        end
    end

    always_comb begin
        status_w           = '0;
        status_w[AW-1:0]   = q.waddr;
        status_w[DW-1]     = q.full;
        status_w[DW-2]     = q.eq;
        status_w[DW-3]     = (q.st == ST_DONE);
        case (cfg_addr)
            RA_CTRL:   cfg_rdata = q.ctrl;
            RA_PAT_A:  cfg_rdata = q.pat_a;
            RA_MASK_A: cfg_rdata = q.mask_a;
            RA_PAT_B:  cfg_rdata = q.pat_b;
            RA_MASK_B: cfg_rdata = q.mask_b;
            RA_STATUS: cfg_rdata = status_w;
            RA_IDX:    cfg_rdata = DW'(q.ridx);
            RA_TRACE:  cfg_rdata = trace_word;
            default:   cfg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign eq_out = q.eq;

    // R12
    eq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_out && !(cfg_we && cfg_addr == RA_STATUS && cfg_wdata[0])) |=> eq_out)
        else $error("eq_out dropped without a clear");

    // R11
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !(cfg_we && cfg_addr == RA_STATUS && cfg_wdata[1])) |=> q.full)
        else $error("full flag dropped without a clear");

    // R11
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> (q.waddr == $past(q.waddr) || q.waddr == $past(q.waddr) + 1'b1
                     || (q.waddr == '0 && $past(q.waddr) == LAST)))
        else $error("write address moved by more than one");

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DONE && !cfg_we) |=> q.st == ST_DONE)
        else $error("finished protocol left done without a write");

    // R10
    brk_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && q.ctrl[2:1] == 2'b11) |=> $stable(q.waddr))
        else $error("breakpoint protocol stored a word");

endmodule

// File: tb/bus_event_monitor_tb.sv
module bus_event_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic [2:0]  bus_strobe = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        eq_in = 1'b0;
    logic        eq_out;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [15:0] last_rd;

    // behavioural reference state
    logic [15:0] m_ctrl = 0, m_pa = 0, m_ma = 0, m_pb = 0, m_mb = 0;
    int          m_addr = 0, m_idx = 0, m_st = 0;   // st: 0 wait, 1 run, 2 done
    bit          m_full = 0, m_eq = 0;
    logic [15:0] mmem [1024];
    bit          mwr  [1024];

    always #5 clk = ~clk;

    bus_event_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_strobe(bus_strobe),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .eq_in(eq_in), .eq_out(eq_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_match(logic [15:0] b, logic [15:0] p, logic [15:0] m, bit ei);
        bit ok = 1;
        for (int i = 0; i < 16; i++)
            if (!m[i] && b[i] != p[i]) ok = 0;
        if (m_ctrl[8] && !ei) ok = 0;
        return ok;
    endfunction

    function automatic bit m_qual(logic [2:0] s);
        int nsel = 0, nhi = 0;
        bit r;
        for (int i = 0; i < 3; i++)
            if (m_ctrl[4+i]) begin nsel++; if (s[i]) nhi++; end
        r = m_ctrl[7] ? (nhi == nsel) : (nhi > 0);
        return r ^ m_ctrl[3];
    endfunction

    function automatic logic [15:0] m_read(logic [3:0] a);
        case (a)
            0: return m_ctrl;
            1: return m_pa;
            2: return m_ma;
            3: return m_pb;
            4: return m_mb;
            5: return {m_full, m_eq, (m_st == 2), 3'b000, 10'(m_addr)};
            6: return 16'(m_idx);
            7: return mmem[m_idx];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic m_step(bit we, logic [3:0] a, logic [15:0] d, logic [15:0] b, logic [2:0] s, bit ei);
        bit ha, hb, st;
        int p;
        if (we) begin
            case (a)
                0: begin m_ctrl = d; m_st = 0; end
                1: m_pa = d;
                2: m_ma = d;
                3: m_pb = d;
                4: m_mb = d;
                5: begin
                    if (d[0]) m_eq = 0;
                    if (d[1]) begin m_addr = 0; m_full = 0; m_st = 0; end
                end
                6: m_idx = int'(d[9:0]);
                default: ;
            endcase
            return;
        end
        if (!m_ctrl[9] || m_st == 2 || !m_qual(s)) return;
        ha = m_match(b, m_pa, m_ma, ei);
        hb = m_match(b, m_pb, m_mb, ei);
        p  = int'(m_ctrl[2:0]);
        st = 0;
        case (p)
            0: st = 1;
            1: if (ha) begin st = 1; m_eq = 1; end
            2: if (m_st == 1 || ha) begin
                   st = 1; m_st = 1;
                   if (hb) begin m_st = 2; m_eq = 1; end
               end
            3: if (m_st == 0) begin if (ha) begin st = 1; m_st = 1; end end
               else if (hb) begin m_st = 0; m_eq = 1; end
               else st = 1;
            4: if (m_st == 1 || ha) begin st = 1; m_st = 1; end
            5: if (hb) begin m_st = 2; m_eq = 1; end else st = 1;
            6: if (ha) m_eq = 1;
            default: if (m_st == 0) begin if (ha) m_st = 1; end
                     else if (hb) begin m_st = 2; m_eq = 1; end
        endcase
        if (st) begin
            mmem[m_addr] = b;
            mwr[m_addr]  = 1;
            if (m_addr == 1023) begin
                m_addr = 0; m_full = 1;
                if (p == 4) begin m_st = 2; m_eq = 1; end
            end else m_addr++;
        end
    endtask

    // one clock: drive, compare against the reference, advance the reference
    task automatic cyc(bit we, logic [3:0] a, logic [15:0] d, logic [15:0] b, logic [2:0] s, bit ei);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        bus_data = b; bus_strobe = s; eq_in = ei;
        #1;
        last_rd = cfg_rdata;
        check("R12 eq_out per cycle", {15'd0, eq_out}, {15'd0, m_eq});
        if (!(a == 4'd7 && !mwr[m_idx]))
            check("R13 readback per cycle", cfg_rdata, m_read(a));
        m_step(we, a, d, b, s, ei);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        cyc(1, a, d, 16'h0000, 3'b000, 0);
    endtask

    task automatic bus(logic [15:0] b);
        cyc(0, 4'd5, 16'h0, b, 3'b000, 0);
    endtask

    task automatic chk_rd(string tag, logic [3:0] a, logic [15:0] exp);
        cyc(0, a, 16'h0, 16'h0000, 3'b000, 0);
        check(tag, last_rd, exp);
    endtask

    task automatic chk_trace(string tag, int i, logic [15:0] exp);
        wr(4'd6, 16'(i));
        chk_rd(tag, 4'd7, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mmem[i] = 0; mwr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd("R1 ctrl after reset", 4'd0, 16'h0000);
        chk_rd("R1 status after reset", 4'd5, 16'h0000);
        check("R1 eq_out after reset", {15'd0, eq_out}, 16'h0000);

        // R4 protocol 0, qualifier always (AND of nothing)
        wr(4'd5, 16'h0003);
        wr(4'd0, 16'h0280);
        for (int i = 1; i <= 5; i++) bus(16'h1111 * 16'(i));
        wr(4'd0, 16'h0000);
        chk_rd("R4 five words stored", 4'd5, 16'h0005);
        for (int i = 0; i < 5; i++) chk_trace("R4 trace content", i, 16'h1111 * 16'(i + 1));

        // R3 qualifier: OR of strobe0, then inverted AND of strobes 1,2
        wr(4'd5, 16'h0003);
        wr(4'd0, 16'h0210);
        cyc(0, 4'd5, 0, 16'hA001, 3'b001, 0);
        cyc(0, 4'd5, 0, 16'hA002, 3'b000, 0);
        cyc(1, 4'd1, 16'h0000, 16'hA0FF, 3'b001, 0);   // write cycle: not sampled
        cyc(0, 4'd5, 0, 16'hA003, 3'b011, 0);
        cyc(0, 4'd5, 0, 16'hA004, 3'b010, 0);
        wr(4'd0, 16'h02E8);
        cyc(0, 4'd5, 0, 16'hB001, 3'b110, 0);
        cyc(0, 4'd5, 0, 16'hB002, 3'b010, 0);
        wr(4'd0, 16'h0000);
        chk_rd("R3 qualified count", 4'd5, 16'h0003);
        chk_trace("R3 second stored", 1, 16'hA003);
        chk_trace("R3 inverted AND stored", 2, 16'hB002);

        // R2 + R5 masked compare and cascade, protocol 1
        wr(4'd5, 16'h0003);
        wr(4'd1, 16'h12F0);
        wr(4'd2, 16'h000F);
        chk_rd("R13 pattern readback", 4'd1, 16'h12F0);
        wr(4'd0, 16'h0281);
        bus(16'h12F5);
        bus(16'h13F5);
        bus(16'h12F0);
        wr(4'd0, 16'h0381);
        cyc(0, 4'd5, 0, 16'h12F1, 3'b000, 0);
        cyc(0, 4'd5, 0, 16'h12F2, 3'b000, 1);
        wr(4'd0, 16'h0000);
        chk_rd("R5 A-only store count and eq", 4'd5, 16'h4003);
        chk_trace("R2 masked bits ignored", 0, 16'h12F5);
        chk_trace("R2 cascade gated hit", 2, 16'h12F2);

        // R6 protocol 2 start/stop
        wr(4'd5, 16'h0003);
        wr(4'd1, 16'hAAAA); wr(4'd2, 16'h0000);
        wr(4'd3, 16'hBBBB); wr(4'd4, 16'h0000);
        wr(4'd0, 16'h0282);
        bus(16'h0001); bus(16'hAAAA); bus(16'h0002); bus(16'hBBBB); bus(16'h0003);
        chk_rd("R6 start..stop inclusive", 4'd5, 16'h6003);
        chk_trace("R6 stop word stored", 2, 16'hBBBB);
        wr(4'd5, 16'h0003);
        wr(4'd3, 16'hAAAA);
        bus(16'h0001); bus(16'hAAAA); bus(16'h0004);
        chk_rd("R6 A and B same word", 4'd5, 16'h6001);

        // R7 protocol 3 pause/resume
        wr(4'd5, 16'h0003);
        wr(4'd3, 16'hBBBB);
        wr(4'd0, 16'h0283);
        bus(16'hAAAA); bus(16'h0001); bus(16'hBBBB); bus(16'h0002); bus(16'hAAAA); bus(16'h0003);
        wr(4'd4, 16'hFFFF);
        bus(16'hAAAA); bus(16'hAAAA);
        wr(4'd0, 16'h0000);
        chk_rd("R7 pause word not stored", 4'd5, 16'h4005);
        chk_trace("R7 resume after pause", 3, 16'h0003);
        chk_trace("R7 A resumes while paused", 4, 16'hAAAA);

        // R9 protocol 5 store until B
        wr(4'd5, 16'h0003);
        wr(4'd4, 16'h0000);
        wr(4'd0, 16'h0285);
        bus(16'h0101); bus(16'h0202); bus(16'hBBBB); bus(16'h0303);
        chk_rd("R9 store until B", 4'd5, 16'h6002);

        // R10 protocol 6 and 7 breakpoints
        wr(4'd5, 16'h0003);
        wr(4'd0, 16'h0286);
        bus(16'h0001); bus(16'hAAAA); bus(16'h0002);
        chk_rd("R10 A breakpoint no store", 4'd5, 16'h4000);
        wr(4'd5, 16'h0003);
        wr(4'd0, 16'h0287);
        bus(16'hBBBB);
        chk_rd("R10 B before A ignored", 4'd5, 16'h0000);
        bus(16'hAAAA); bus(16'hBBBB);
        chk_rd("R10 A then B halts", 4'd5, 16'h6000);
        wr(4'd5, 16'h0003);
        wr(4'd4, 16'hFFFF);
        wr(4'd0, 16'h0217);
        cyc(0, 4'd5, 0, 16'hAAAA, 3'b001, 0);
        chk_rd("R10 same-word A does not halt", 4'd5, 16'h0000);
        cyc(0, 4'd5, 0, 16'h0005, 3'b001, 0);
        chk_rd("R10 later B halts", 4'd5, 16'h6000);

        // R8 + R11 protocol 4 fill, wrap
        wr(4'd5, 16'h0003);
        wr(4'd4, 16'h0000);
        wr(4'd0, 16'h0284);
        bus(16'h0001); bus(16'hAAAA);
        for (int k = 1; k <= 1029; k++) bus(16'(k));
        chk_rd("R8 R11 fill stops with full", 4'd5, 16'hE000);
        chk_trace("R11 last address", 1023, 16'h03FF);
        chk_trace("R8 first word", 0, 16'hAAAA);

        // R12 clears
        wr(4'd5, 16'h0001);
        chk_rd("R12 eq clear keeps full", 4'd5, 16'hA000);
        wr(4'd5, 16'h0002);
        chk_rd("R12 pointer clear", 4'd5, 16'h0000);
        check("R12 eq_out low after clear", {15'd0, eq_out}, 16'h0000);
        chk_rd("R13 unused address", 4'd9, 16'h0000);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule